// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This controller puts a small microcontroller core to sleep and wakes it again. The core raises a one-cycle sleep request together with a 3-bit mode code and a sleep-enable bit. The controller then switches off a mode-dependent set of clock domains: CPU, flash, I/O and ADC. It also drops the main oscillator enable in the deepest mode. While the core sleeps, the controller filters a vector of wake-up sources through a per-mode mask. When an accepted source fires, it restores the clocks, either at once or after a start-up delay, and pulses a wake acknowledge to the core.

Four modes are legal:
- Idle stops only the CPU and flash clocks.
- ADC-quiet mode also stops the I/O clock.
- Deep power-down stops every clock and the oscillator.
- Standby matches deep power-down but keeps the oscillator running, so it wakes after a short fixed delay.

Deep power-down wakes after a programmable oscillator settling period. In the two deep modes, a level interrupt is accepted only after it has been held for a minimum time. Entering Idle or ADC-quiet mode with the ADC enabled pulses an ADC start. A reset event from any source returns the block to the awake state at once.

The controller runs on a free-running always-on reference clock. The gated domain clocks are produced downstream from its enable outputs.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low), asleep is 0, all four clock enables and osc_en are 1, and adc_autostart and wake_ack are 0.
- R2: A request with mode_sel 3'b000 (Idle) makes asleep 1 one cycle later, with CPU and flash enables 0 and I/O, ADC and oscillator enables 1.
- R3: A request with mode_sel 3'b001 (ADC-quiet) gates the CPU, flash and I/O clocks and keeps the ADC clock and the oscillator enabled.
- R4: A request with mode_sel 3'b010 (deep power-down) drops all four clock enables and osc_en.
- R5: A request with mode_sel 3'b110 (Standby) while xtal_sel is 1 drops all four clock enables and keeps osc_en 1. With xtal_sel 0 the same request behaves exactly as deep power-down, in gating and in wake latency.
- R6: A request is ignored when sleep_en is 0 or mode_sel is 3'b011, 3'b100, 3'b101 or 3'b111. The block stays awake with all enables 1.
- R7: The wake_src bits are 0 level interrupt, 1 PWM-controller interrupt, 2 timer, 3 NVM ready, 4 ADC done and 5 other I/O. Idle accepts all of them. ADC-quiet accepts bits 0, 2, 3 and 4. The two deep modes accept bits 0 and 1. Any other bit leaves the block asleep.
- R8: In Idle and ADC-quiet mode, an accepted source restores all enables one cycle after it is sampled. wake_ack is 1 for exactly that one cycle.
- R9: In Standby with the crystal option, the clocks return 6 cycles after the cycle in which the wake is detected.
- R10: In deep power-down, the clocks return pd_start_cycles cycles after detection. A value of 0 means immediate return.
- R11: In the two deep modes, the level-interrupt bit is detected only after LVL_HOLD (default 3) consecutive high samples. A shorter pulse does not wake the block.
- R12: adc_autostart is 1 for one cycle, in the first asleep cycle, when Idle or ADC-quiet mode is entered with adc_en 1. It stays 0 for all other entries.
- R13: rst_evt returns the block to awake with all enables 1 in the next cycle from any sleep or start-up state, and without a wake_ack pulse.
- R14: During the start-up delay, the four clock enables stay 0 and osc_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| sleep_en | input | 1 | Sleep permit bit |
| mode_sel | input | 3 | Requested sleep mode code |
| xtal_sel | input | 1 | Crystal/resonator clock option selected |
| adc_en | input | 1 | ADC enabled |
| wake_src | input | 6 | Wake-up source vector (bit map in R7) |
| rst_evt | input | 1 | Any reset event (pin, watchdog, brown-out) |
| pd_start_cycles | input | 8 | Start-up delay for deep power-down |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_autostart | output | 1 | ADC conversion start pulse |
| wake_ack | output | 1 | Wake acknowledge pulse to the core |
| asleep | output | 1 | Core is held in sleep or start-up |

## Verification
The bench sweeps every combination of mode code, sleep_en, crystal option and ADC enable through a sleep entry. This separates the four legal gating patterns from the ignored requests and shows which entries start the ADC. For each legal mode, each of the six wake sources is then raised alone. This tells masked sources (the block stays asleep) from accepted ones, and the measured wake latency tells the immediate, fixed-six, programmable and level-hold paths apart. Extra runs cover a zero and a long power-down delay, a level pulse one sample too short, and a reset event that lands in the middle of the start-up count.

// File: rtl/sleep_ctl_pkg.sv
// Shared constants and types for the sleep clock gating controller.
// Assumes: mode codes are 3 bits; wake vector is six bits wide.
package sleep_ctl_pkg;
    localparam logic [2:0] MODE_IDLE  = 3'b000;
    localparam logic [2:0] MODE_ADCQ  = 3'b001;
    localparam logic [2:0] MODE_PDOWN = 3'b010;
    localparam logic [2:0] MODE_STBY  = 3'b110;

    localparam int WAKE_W = 6;
    localparam int WK_LVL = 0;
    localparam int WK_PWM = 1;
    localparam int WK_TMR = 2;
    localparam int WK_NVM = 3;
    localparam int WK_ADC = 4;
    localparam int WK_OTH = 5;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic osc;
    } gate_t;

    typedef enum logic [1:0] {
        ST_AWAKE   = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_STARTUP = 2'd2
    } slp_state_e;
endpackage

// File: rtl/sleep_mode_decode.sv
// Mode decoder: checks a requested code for legality, maps Standby without
// the crystal option onto deep power-down, and gives the clock gates and wake
// mask of the mode currently held. Purely combinational.
// Assumes: cur_mode only ever holds one of the four legal codes.
module sleep_mode_decode
    import sleep_ctl_pkg::*;
(
    input  logic [2:0]        req_mode,
    input  logic              xtal_ok,
    input  logic [2:0]        cur_mode,
    output logic              req_legal,
    output logic [2:0]        req_eff,
    output gate_t             cur_gate,
    output logic [WAKE_W-1:0] cur_mask,
    output logic              cur_hold
);
    // Legality and effective mode of an incoming request.
    always_comb begin
        req_legal = 1'b1;
        req_eff   = req_mode;
        case (req_mode)
            MODE_IDLE, MODE_ADCQ, MODE_PDOWN: ;
            MODE_STBY: if (!xtal_ok) req_eff = MODE_PDOWN;
            default:   req_legal = 1'b0;
        endcase
    end

    // Gate pattern, wake mask and level-hold need of the held mode.
    always_comb begin
        cur_gate = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
        cur_mask = '0;
        cur_hold = 1'b0;
        case (cur_mode)
            MODE_IDLE: begin
                cur_gate.io  = 1'b1;
                cur_gate.adc = 1'b1;
                cur_gate.osc = 1'b1;
                cur_mask     = '1;
            end
            MODE_ADCQ: begin
                cur_gate.adc     = 1'b1;
                cur_gate.osc     = 1'b1;
                cur_mask[WK_LVL] = 1'b1;
                cur_mask[WK_TMR] = 1'b1;
                cur_mask[WK_NVM] = 1'b1;
                cur_mask[WK_ADC] = 1'b1;
            end
            MODE_STBY: begin
                cur_gate.osc     = 1'b1;
                cur_mask[WK_LVL] = 1'b1;
                cur_mask[WK_PWM] = 1'b1;
                cur_hold         = 1'b1;
            end
            default: begin
                cur_mask[WK_LVL] = 1'b1;
                cur_mask[WK_PWM] = 1'b1;
                cur_hold         = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sleep_lvl_filter.sv
// Level-interrupt hold filter: counts consecutive high samples while armed and
// accepts the level once HOLD samples have been seen.
// Assumes: HOLD >= 1; disarming or a low sample restarts the count.
module sleep_lvl_filter #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic lvl_in,
    output logic lvl_ok
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HMAX = HW'(HOLD);

    logic [HW-1:0] cnt_q;

    // Saturating count of consecutive armed high samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !lvl_in) cnt_q <= '0;
        else if (cnt_q != HMAX)        cnt_q <= cnt_q + 1'b1;
    end

    assign lvl_ok = arm && lvl_in && (cnt_q == HMAX);

    // R11: acceptance needs the level to have been high on the previous sample too.
    p_hold_before_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_ok |-> $past(lvl_in));
endmodule

// File: rtl/sleep_wake_timer.sv
// Start-up delay counter: loaded with the settling period on a wake event,
// counts down once per cycle, flags the last cycle.
// Assumes: load is only issued with a non-zero value.
module sleep_wake_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    // Down-counter with clear priority over load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)    cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == {{(CW-1){1'b0}}, 1'b1});

    // R10: an idle running count drops by exactly one each cycle.
    p_countdown_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
// Sleep clock gating controller top: accepts sleep requests, holds the
// effective mode, gates clock domains, filters wake sources and sequences
// the start-up delay before releasing the clocks.
// Assumes: clk is an always-on reference that keeps running in every mode.
module sleep_clkgate_ctrl
    import sleep_ctl_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SB_DELAY = 6,
    parameter int LVL_HOLD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             sleep_en,
    input  logic [2:0]       mode_sel,
    input  logic             xtal_sel,
    input  logic             adc_en,
    input  logic [5:0]       wake_src,
    input  logic             rst_evt,
    input  logic [CNT_W-1:0] pd_start_cycles,
    output logic             clk_en_cpu,
    output logic             clk_en_flash,
    output logic             clk_en_io,
    output logic             clk_en_adc,
    output logic             osc_en,
    output logic             adc_autostart,
    output logic             wake_ack,
    output logic             asleep
);
    localparam logic [CNT_W-1:0] SB_LAT = CNT_W'(SB_DELAY);

    slp_state_e        state_q, state_d;
    logic [2:0]        mode_q, mode_d;
    logic              req_legal, cur_hold, lvl_ok, tmr_done;
    logic [2:0]        req_eff;
    gate_t             cur_gate;
    logic [WAKE_W-1:0] cur_mask, src_eff;
    logic              wake_hit, go_sleep, do_ack, tmr_load;
    logic [CNT_W-1:0]  lat;

    sleep_mode_decode u_dec (
        .req_mode (mode_sel),
        .xtal_ok  (xtal_sel),
        .cur_mode (mode_q),
        .req_legal(req_legal),
        .req_eff  (req_eff),
        .cur_gate (cur_gate),
        .cur_mask (cur_mask),
        .cur_hold (cur_hold)
    );

    sleep_lvl_filter #(.HOLD(LVL_HOLD)) u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (state_q == ST_SLEEP && cur_hold),
        .lvl_in(wake_src[WK_LVL]),
        .lvl_ok(lvl_ok)
    );

    sleep_wake_timer #(.CW(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rst_evt),
        .load    (tmr_load),
        .load_val(lat),
        .done    (tmr_done)
    );

    // Wake sources after the mode mask, level bit through the hold filter in deep modes.
    always_comb begin
        src_eff = wake_src & cur_mask;
        if (cur_hold) src_eff[WK_LVL] = lvl_ok;
        wake_hit = |src_eff;
    end

    // Start-up latency of the held mode.
    always_comb begin
        case (mode_q)
            MODE_PDOWN: lat = pd_start_cycles;
            MODE_STBY:  lat = SB_LAT;
            default:    lat = '0;
        endcase
    end

    // Next-state logic; reset events take priority everywhere.
    always_comb begin
        state_d  = state_q;
        mode_d   = mode_q;
        go_sleep = 1'b0;
        do_ack   = 1'b0;
        tmr_load = 1'b0;
        case (state_q)
            ST_AWAKE: if (!rst_evt && sleep_req && sleep_en && req_legal) begin
                state_d  = ST_SLEEP;
                mode_d   = req_eff;
                go_sleep = 1'b1;
            end
            ST_SLEEP: begin
                if (rst_evt) state_d = ST_AWAKE;
                else if (wake_hit) begin
                    if (lat == '0) begin
                        state_d = ST_AWAKE;
                        do_ack  = 1'b1;
                    end else begin
                        state_d  = ST_STARTUP;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: begin
                if (rst_evt) state_d = ST_AWAKE;
                else if (tmr_done) begin
                    state_d = ST_AWAKE;
                    do_ack  = 1'b1;
                end
            end
        endcase
    end

    // State, held mode and the two output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_AWAKE;
            mode_q        <= MODE_IDLE;
            adc_autostart <= 1'b0;
            wake_ack      <= 1'b0;
        end else begin
            state_q       <= state_d;
            mode_q        <= mode_d;
            adc_autostart <= go_sleep && adc_en &&
                             (req_eff == MODE_IDLE || req_eff == MODE_ADCQ);
            wake_ack      <= do_ack;
        end
    end

    assign asleep       = (state_q != ST_AWAKE);
    assign clk_en_cpu   = !asleep || (state_q == ST_SLEEP && cur_gate.cpu);
    assign clk_en_flash = !asleep || (state_q == ST_SLEEP && cur_gate.flash);
    assign clk_en_io    = !asleep || (state_q == ST_SLEEP && cur_gate.io);
    assign clk_en_adc   = !asleep || (state_q == ST_SLEEP && cur_gate.adc);
    assign osc_en       = !asleep || (state_q == ST_STARTUP) || cur_gate.osc;

    // R8: a wake acknowledge only follows a cycle spent asleep.
    p_ack_after_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |-> (!asleep && $past(asleep)));

    // R13: a reset event always leaves the block awake on the next cycle.
    p_reset_event_wakes_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> !asleep);

    // R14: during start-up the domain clocks stay off and the oscillator runs.
    p_startup_gated_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP) |-> (osc_en && !clk_en_cpu && !clk_en_io && !clk_en_adc));

    // R12: the ADC start pulse appears only in the first asleep cycle.
    p_autostart_on_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        adc_autostart |-> (asleep && $past(!asleep)));
endmodule

// File: tb/sleep_clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_clkgate_ctrl_tb_top;
    localparam int HOLD = 3;
    localparam int SBL  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, sleep_en = 1'b0, xtal_sel = 1'b0, adc_en = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic [5:0] wake_src = '0;
    logic       rst_evt = 1'b0;
    logic [7:0] pd_start_cycles = 8'd5;
    logic       clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, osc_en;
    logic       adc_autostart, wake_ack, asleep;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sleep_clkgate_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
        .mode_sel(mode_sel), .xtal_sel(xtal_sel), .adc_en(adc_en),
        .wake_src(wake_src), .rst_evt(rst_evt), .pd_start_cycles(pd_start_cycles),
        .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
        .clk_en_adc(clk_en_adc), .osc_en(osc_en), .adc_autostart(adc_autostart),
        .wake_ack(wake_ack), .asleep(asleep)
    );

    function automatic logic [4:0] gates_now();
        return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, osc_en};
    endfunction

    // Legal modes per R2..R6.
    function automatic bit is_legal(int m);
        return (m == 0 || m == 1 || m == 2 || m == 6);
    endfunction

    // Effective mode: Standby without crystal falls back to power-down (R5).
    function automatic int eff_mode(int m, bit x);
        return (m == 6 && !x) ? 2 : m;
    endfunction

    // Asleep gating pattern {cpu,flash,io,adc,osc} from R2..R5.
    function automatic logic [4:0] exp_gates(int m);
        case (m)
            0: return 5'b00111;
            1: return 5'b00011;
            6: return 5'b00001;
            default: return 5'b00000;
        endcase
    endfunction

    // Accepted wake sources from R7.
    function automatic bit src_ok(int m, int s);
        case (m)
            0: return 1'b1;
            1: return (s == 0 || s == 2 || s == 3 || s == 4);
            default: return (s == 0 || s == 1);
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enter(int m, bit en, bit x, bit a);
        @(negedge clk);
        mode_sel = 3'(m); sleep_en = en; xtal_sel = x; adc_en = a; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic kick_reset_evt();
        rst_evt = 1'b1;
        @(negedge clk);
        rst_evt = 1'b0;
        chk("R13 asleep after reset event", asleep, 0);
        chk("R13 no wake_ack on reset event", wake_ack, 0);
        chk("R13 gates after reset event", gates_now(), 5'b11111);
    endtask

    // Raise one source alone and measure cycles until awake.
    task automatic wake_run(int m, bit x, int s, int pdc);
        int em, lat, n;
        bit gated_ok;
        pd_start_cycles = 8'(pdc);
        enter(m, 1'b1, x, 1'b0);
        em = eff_mode(m, x);
        wake_src = 6'(1 << s);
        n = 0;
        gated_ok = 1'b1;
        while (n < 60) begin
            @(negedge clk);
            n++;
            if (!asleep) break;
            if (clk_en_cpu || !(osc_en || em == 2)) gated_ok = 1'b0;
        end
        lat = 1;
        if (s == 0 && (em == 2 || em == 6)) lat += HOLD;
        if (em == 6) lat += SBL;
        if (em == 2) lat += pdc;
        if (src_ok(em, s)) begin
            chk($sformatf("R7/R8/R9/R10/R11 latency mode%0d src%0d", m, s), n, lat);
            chk("R8 wake_ack on wake", wake_ack, 1);
            @(negedge clk);
            chk("R8 wake_ack one cycle", wake_ack, 0);
            chk("R14 gating during start-up", gated_ok, 1);
        end else begin
            chk($sformatf("R7 masked mode%0d src%0d stays asleep", m, s), asleep, 1);
            kick_reset_evt();
        end
        wake_src = '0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 asleep", asleep, 0);
        chk("R1 gates", gates_now(), 5'b11111);
        chk("R1 pulses", {adc_autostart, wake_ack}, 0);

        // Entry sweep over every code, enable, crystal and ADC setting (R2..R6, R12).
        for (int m = 0; m < 8; m++)
            for (int e = 0; e < 2; e++)
                for (int x = 0; x < 2; x++)
                    for (int a = 0; a < 2; a++) begin
                        bit go;
                        int em;
                        enter(m, e[0], x[0], a[0]);
                        go = e[0] && is_legal(m);
                        em = eff_mode(m, x[0]);
                        chk($sformatf("R2/R3/R4/R5/R6 asleep code%0d en%0d", m, e), asleep, go);
                        chk($sformatf("R2/R3/R4/R5/R6 gates code%0d xtal%0d", m, x),
                            gates_now(), go ? exp_gates(em) : 5'b11111);
                        chk($sformatf("R12 autostart code%0d adc%0d", m, a), adc_autostart,
                            go && a[0] && (em == 0 || em == 1));
                        @(negedge clk);
                        chk("R12 autostart single cycle", adc_autostart, 0);
                        if (go) kick_reset_evt();
                    end

        // Wake sweep, each source alone in each legal mode (R7..R11, R14).
        for (int s = 0; s < 6; s++) begin
            wake_run(0, 1'b1, s, 5);
            wake_run(1, 1'b1, s, 5);
            wake_run(2, 1'b1, s, 5);
            wake_run(6, 1'b1, s, 5);
            wake_run(6, 1'b0, s, 5);
        end
        // R10 zero and long power-down delays
        wake_run(2, 1'b1, 1, 0);
        wake_run(2, 1'b1, 1, 17);
        wake_run(2, 1'b1, 0, 0);

        // R11 level pulse one sample short of the hold time
        enter(2, 1'b1, 1'b1, 1'b0);
        wake_src = 6'b000001;
        repeat (HOLD - 1) @(negedge clk);
        wake_src = '0;
        repeat (10) @(negedge clk);
        chk("R11 short level pulse ignored", asleep, 1);
        kick_reset_evt();

        // R13 reset event in the middle of the start-up count
        pd_start_cycles = 8'd20;
        enter(2, 1'b1, 1'b1, 1'b0);
        wake_src = 6'b000010;
        repeat (5) @(negedge clk);
        chk("R14 still in start-up", asleep, 1);
        chk("R14 osc on, clocks off in start-up", gates_now(), 5'b00001);
        wake_src = '0;
        kick_reset_evt();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule